// File: doc/BRIEF.md
# Two-Channel Scan Sequencer

This block decides when an analog front end starts a conversion and which of its two inputs that conversion samples. A host sets an operating-mode code, two channel-enable bits, an input-arrangement code and a conversion cycle length counted in oscillator clocks, then pulses a start strobe. The block answers with one-cycle conversion-start pulses, each tagged with a channel number, and holds a busy line high for as long as the sequence runs.

Three behaviours follow from the mode code. A single-shot mode converts channel 0 once. A stepping mode converts the next enabled channel once per start, so repeated starts walk round the enabled set. A burst mode (used for both the autonomous and the high-precision codes) issues a fixed number of conversions, one per cycle, rotating over the enabled channels. A configuration that cannot be run raises an error flag, and the block then stays idle. An abort strobe ends any run at the next clock. An external calibration-active input also holds busy high.

Top module: `scan_seq`

## Requirements
- R1: After reset busy_o, conv_go_o and seq_err_o are 0 and conv_ch_o is 0; a start in mode 000 then gives one pulse on channel 0.
- R2: Mode codes: 000, 001, 010 and 011 give one conversion of channel 0 whatever the enable bits; 100 and 101 give one conversion of the next enabled channel; 110 and 111 give SEQ_LEN (default 16) conversions.
- R3: Scan modes convert only enabled channels, alternating when both are enabled; a burst begins at channel 0 if it is enabled, otherwise at channel 1; a step takes the enabled channel after the last one converted in a scan mode (channel 0 after reset when enabled).
- R4: Input-arrangement codes 00 and 11 mean two single-ended inputs and 01 and 10 a single input; in a scan mode a start with code 01 or 10 and channel 1 enabled sets seq_err_o, gives no pulse and leaves busy_o low.
- R5: In a scan mode a start with both enable bits 0 sets seq_err_o, gives no pulse and leaves busy_o low.
- R6: seq_err_o stays set until a start that is accepted and valid, which clears it in the same clock that begins the run.
- R7: The first pulse follows the start clock by one cycle, and further pulses come exactly every cyc_len_i clocks (0 counts as 1), so one channel recurs every (enabled count × cyc_len_i) clocks.
- R8: busy_o is high for exactly (conversions × cyc_len_i) cycles starting the cycle after an accepted start, then falls.
- R9: abort_i drops busy_o and stops all pulses from the next clock, including a pulse due that clock, keeps seq_err_o, and takes priority over a start in the same cycle.
- R10: cal_busy_i held high forces busy_o high in the same cycle.
- R11: A start while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Operating-mode code |
| ch_en_i | input | 2 | Channel enables, bit n for channel n |
| in_cfg_i | input | 2 | Input-arrangement code |
| cyc_len_i | input | CYC_W | Clocks per conversion cycle |
| start_i | input | 1 | Start strobe |
| abort_i | input | 1 | Abort strobe |
| cal_busy_i | input | 1 | Offset calibration in progress |
| conv_go_o | output | 1 | One-cycle conversion start |
| conv_ch_o | output | 1 | Channel of the current conversion |
| busy_o | output | 1 | Sequence or calibration active |
| seq_err_o | output | 1 | Sequence configuration error flag |

## Verification
The assertions take for granted that the mode, enable, arrangement and cycle-length inputs need only be valid in the clock where a start is taken, since the block latches them there; the spacing check relies on that latched length and not on the live input. The stimulus holds every configuration input steady across each run and changes it only while the block is idle. It sweeps every mode, arrangement and enable code over cycle lengths 0 to 3, then adds directed aborts, an abort paired with a start, a start during a run and calibration.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [1:0] {
    CLS_SINGLE = 2'd0,
    CLS_STEP   = 2'd1,
    CLS_BURST  = 2'd2
  } seq_cls_t;

  // R2: mode code to behaviour class
  function automatic seq_cls_t decode_mode(logic [2:0] code);
    seq_cls_t c;
    case (code)
      3'b110, 3'b111: c = CLS_BURST;
      3'b100, 3'b101: c = CLS_STEP;
      default:        c = CLS_SINGLE;
    endcase
    return c;
  endfunction

  // R3: enabled channel that follows the given one
  function automatic logic next_ch(logic cur, logic [1:0] en);
    return en[~cur] ? ~cur : cur;
  endfunction

endpackage

// File: rtl/scan_cfg_check.sv
module scan_cfg_check
  import scan_seq_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic [1:0] ch_en_i,
  input  logic [1:0] in_cfg_i,
  input  logic       last_ch_i,
  output seq_cls_t   cls_o,
  output logic       bad_o,
  output logic [1:0] en_eff_o,
  output logic       first_ch_o
);

  logic one_input;

  always_comb begin
    cls_o     = decode_mode(mode_i);
    one_input = ^in_cfg_i;                       // R4: codes 01, 10
    bad_o     = (cls_o != CLS_SINGLE) &&
                ((ch_en_i == 2'b00) ||           // R5
                 (one_input && ch_en_i[1]));     // R4
    en_eff_o  = (cls_o == CLS_SINGLE) ? 2'b01 : ch_en_i;
    case (cls_o)
      CLS_BURST: first_ch_o = ~ch_en_i[0];
      CLS_STEP:  first_ch_o = next_ch(last_ch_i, ch_en_i);
      default:   first_ch_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/scan_cycle_timer.sv
module scan_cycle_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          run_i,
  input  logic [CW-1:0] len_i,
  output logic          wrap_o
);

  logic [CW-1:0] cnt_q, cnt_d, last_val;

  assign last_val = (len_i == '0) ? '0 : len_i - 1'b1;   // R7: 0 acts as 1
  assign wrap_o   = run_i && (cnt_q == last_val);

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)  cnt_d = '0;
    else if (run_i) cnt_d = wrap_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_seq_pkg::*;
#(
  parameter int CYC_W   = 8,
  parameter int SEQ_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_i,
  input  logic [1:0]       ch_en_i,
  input  logic [1:0]       in_cfg_i,
  input  logic [CYC_W-1:0] cyc_len_i,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             cal_busy_i,
  output logic             conv_go_o,
  output logic             conv_ch_o,
  output logic             busy_o,
  output logic             seq_err_o
);

  localparam int LW = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;

  logic             run_q, run_d;
  logic             go_q, go_d;
  logic             ch_q, ch_d;
  logic             last_q, last_d;
  logic             err_q, err_d;
  logic [1:0]       en_q, en_d;
  logic [LW-1:0]    left_q, left_d;
  logic [CYC_W-1:0] len_q, len_d;

  seq_cls_t   cls;
  logic       bad, first_ch, wrap, accept, launch;
  logic [1:0] en_eff;

  scan_cfg_check u_check (
    .mode_i    (mode_i),
    .ch_en_i   (ch_en_i),
    .in_cfg_i  (in_cfg_i),
    .last_ch_i (last_q),
    .cls_o     (cls),
    .bad_o     (bad),
    .en_eff_o  (en_eff),
    .first_ch_o(first_ch)
  );

  // R9 abort beats start, R11 start ignored while running
  assign accept = start_i && !abort_i && !run_q;
  assign launch = accept && !bad;

  scan_cycle_timer #(.CW(CYC_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(launch),
    .run_i    (run_q),
    .len_i    (len_q),
    .wrap_o   (wrap)
  );

  always_comb begin
    run_d  = run_q;
    go_d   = 1'b0;
    ch_d   = ch_q;
    last_d = last_q;
    err_d  = err_q;
    en_d   = en_q;
    left_d = left_q;
    len_d  = len_q;
    if (abort_i) begin
      run_d = 1'b0;                                   // R9
    end else if (accept) begin
      if (bad) begin
        err_d = 1'b1;                                 // R4, R5
      end else begin
        err_d  = 1'b0;                                // R6
        run_d  = 1'b1;
        go_d   = 1'b1;
        ch_d   = first_ch;
        en_d   = en_eff;
        len_d  = cyc_len_i;
        left_d = (cls == CLS_BURST) ? LW'(SEQ_LEN - 1) : '0;   // R2
        if (cls != CLS_SINGLE) last_d = first_ch;
      end
    end else if (wrap) begin
      if (left_q != '0) begin
        go_d   = 1'b1;                                // R7
        ch_d   = next_ch(ch_q, en_q);                 // R3
        last_d = next_ch(ch_q, en_q);
        left_d = left_q - 1'b1;
      end else begin
        run_d = 1'b0;                                 // R8
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      go_q   <= 1'b0;
      ch_q   <= 1'b0;
      last_q <= 1'b1;
      err_q  <= 1'b0;
      en_q   <= 2'b01;
      left_q <= '0;
      len_q  <= '0;
    end else begin
      run_q  <= run_d;
      go_q   <= go_d;
      ch_q   <= ch_d;
      last_q <= last_d;
      err_q  <= err_d;
      en_q   <= en_d;
      left_q <= left_d;
      len_q  <= len_d;
    end
  end

  assign conv_go_o = go_q;
  assign conv_ch_o = ch_q;
  assign busy_o    = run_q || cal_busy_i;             // R10
  assign seq_err_o = err_q;

endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          abort_i,
  input logic          cal_busy_i,
  input logic          conv_go_o,
  input logic          conv_ch_o,
  input logic          busy_o,
  input logic          seq_err_o,
  input logic          run_q,
  input logic [1:0]    en_q,
  input logic [CW-1:0] len_q
);

  logic [CW:0] gap_q, leff;
  logic        seen_q;

  assign leff = (len_q == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, len_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      gap_q  <= conv_go_o ? '0 : gap_q + 1'b1;
      seen_q <= run_q && (conv_go_o || seen_q);
    end
  end

  AST_GO_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go_o && seen_q |-> gap_q == leff - 1'b1);                      // R7
  AST_GO_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go_o |-> busy_o);                                              // R8
  AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !conv_go_o && !run_q);                                  // R9
  AST_CAL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy_i |-> busy_o);                                             // R10
  AST_CH_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go_o |-> en_q[conv_ch_o]);                                     // R3
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err_o && !$past(seq_err_o) |-> !run_q && !conv_go_o);           // R4

endmodule

bind scan_seq scan_seq_chk #(.CW(CYC_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .abort_i   (abort_i),
  .cal_busy_i(cal_busy_i),
  .conv_go_o (conv_go_o),
  .conv_ch_o (conv_ch_o),
  .busy_o    (busy_o),
  .seq_err_o (seq_err_o),
  .run_q     (run_q),
  .en_q      (en_q),
  .len_q     (len_q)
);

// File: tb/scan_seq_tb_top.sv
module scan_seq_tb_top;

  localparam int CW  = 8;
  localparam int SEQ = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    mode;
  logic [1:0]    en, cfg;
  logic [CW-1:0] cyc;
  logic          start, abort, cal;
  logic          go, ch, busy, err;

  int   n_chk = 0, n_fail = 0;
  logic m_last;

  always #10 clk = ~clk;

  scan_seq #(.CYC_W(CW), .SEQ_LEN(SEQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .ch_en_i(en), .in_cfg_i(cfg),
    .cyc_len_i(cyc), .start_i(start), .abort_i(abort), .cal_busy_i(cal),
    .conv_go_o(go), .conv_ch_o(ch), .busy_o(busy), .seq_err_o(err)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic nxt(logic cur, logic [1:0] e);
    return e[~cur] ? ~cur : cur;
  endfunction

  // Full sequence against an arithmetic model; rs >= 0 re-pulses start mid-run (R11)
  task automatic run_case(logic [2:0] m, logic [1:0] c, logic [1:0] e, int L, int rs);
    logic scan, burst, bad, exp_ch;
    int   eff, total;
    scan  = m[2];
    burst = m[2] & m[1];
    eff   = (L == 0) ? 1 : L;
    total = burst ? SEQ : 1;
    bad   = scan && ((e == 2'b00) || ((c == 2'b01 || c == 2'b10) && e[1]));
    @(negedge clk);
    mode = m; cfg = c; en = e; cyc = CW'(L); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (bad) begin
      for (int k = 0; k < 3; k++) begin
        chk((e == 2'b00) ? "R5 err" : "R4 err", err, 1);
        chk((e == 2'b00) ? "R5 busy" : "R4 busy", busy, 0);
        chk((e == 2'b00) ? "R5 go" : "R4 go", go, 0);
        @(negedge clk);
      end
      return;
    end
    exp_ch = burst ? ~e[0] : (scan ? nxt(m_last, e) : 1'b0);
    for (int k = 0; k < total * eff; k++) begin
      if (k > 0 && (k % eff) == 0) exp_ch = nxt(exp_ch, e);
      chk("R8 busy", busy, 1);
      chk("R7 go", go, ((k % eff) == 0) ? 1 : 0);
      if ((k % eff) == 0) chk(scan ? "R3 ch" : "R2 ch", ch, exp_ch);
      chk("R6 err", err, 0);
      start = (k == rs);
      @(negedge clk);
    end
    start = 1'b0;
    if (scan) m_last = exp_ch;
    chk("R8 busy end", busy, 0);
    chk("R2 go end", go, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 3'b000; en = 2'b00; cfg = 2'b00; cyc = '0;
    start = 1'b0; abort = 1'b0; cal = 1'b0; m_last = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 go", go, 0);
    chk("R1 err", err, 0);
    chk("R1 ch", ch, 0);

    // R1: first start in mode 000 converts channel 0
    mode = 3'b000; en = 2'b10; cfg = 2'b01; cyc = CW'(2); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 first go", go, 1);
    chk("R1 first ch", ch, 0);
    repeat (2) @(negedge clk);
    chk("R1 idle", busy, 0);

    // R2..R8 sweep over every code and short cycle lengths
    for (int m = 0; m < 8; m++)
      for (int c = 0; c < 4; c++)
        for (int e = 0; e < 4; e++)
          for (int L = 0; L < 4; L++)
            run_case(3'(m), 2'(c), 2'(e), L, -1);

    // R11: start pulsed mid-burst changes nothing
    run_case(3'b110, 2'b00, 2'b11, 2, 5);
    run_case(3'b101, 2'b11, 2'b11, 3, 1);

    // R9: abort in the cycle before a pulse is due cancels it
    @(negedge clk);
    mode = 3'b111; cfg = 2'b00; en = 2'b11; cyc = CW'(3); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 6; k++) begin
      chk("R9 pre go", go, ((k % 3) == 0) ? 1 : 0);
      if (k < 5) @(negedge clk);
    end
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    m_last = 1'b1;
    chk("R9 busy", busy, 0);
    chk("R9 go", go, 0);
    chk("R9 err", err, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 quiet", go | busy, 0);
    end

    // R9 + R6: error kept across abort; abort beats simultaneous start
    run_case(3'b100, 2'b10, 2'b11, 1, -1);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk("R9 err kept", err, 1);
    mode = 3'b110; cfg = 2'b00; en = 2'b01; start = 1'b1; abort = 1'b1;
    @(negedge clk);
    start = 1'b0; abort = 1'b0;
    chk("R9 start lost busy", busy, 0);
    chk("R9 start lost go", go, 0);
    chk("R6 err still", err, 1);
    run_case(3'b100, 2'b00, 2'b11, 1, -1);

    // R10: calibration holds busy
    @(negedge clk);
    cal = 1'b1;
    #1;
    chk("R10 busy", busy, 1);
    chk("R10 go", go, 0);
    @(negedge clk);
    cal = 1'b0;
    #1;
    chk("R10 release", busy, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule